// File: doc/BRIEF.md
# Queued SPI Transmit Master with Per-Entry Chip Select

This block is a transmit-only SPI master fed by a small queue. Software stages a chip-select pattern, then writes a data word. The data write commits the pair to the queue as one entry. Because each entry carries its own pattern, consecutive words in one burst can be addressed to different slaves. An item-count register defines how many entries make up a burst. A single-cycle completion pulse is raised once that many entries have been shifted out.

The serial clock idles low. Data changes with the falling edge, and the slave samples on the rising edge. Each half period lasts `CLK_DIV` system clocks. Word length, bit order and the active level of every chip-select line are configurable.

If the queue drains before the burst count is reached, the engine waits. In that wait the clock stays low and no slave is selected. Shifting resumes as soon as a new entry arrives. A pointer-clear strobe empties the queue and restarts burst counting, and it is issued before every burst. After a completed burst the engine stays quiet until that clear arrives.

Top module: `qspi_tx_fifo`

## Requirements
- R1: An entry is committed only by a data write (`dat_wr`), and it takes the chip-select pattern most recently staged by `cs_wr`. Chip-select writes on their own queue nothing and shift nothing.
- R2: The queue holds 16 entries. `fifo_full` is 1 exactly while 16 entries are held. A data write while full is discarded and does not displace any stored entry.
- R3: A `ptr_clr` pulse discards every queued entry, drops `fifo_full` and restarts the burst count from zero. Entries written before the clear are never transmitted.
- R4: Shifting happens only while `tx_en` is 1. With `tx_en` at 0, `sclk` stays low and every chip-select line is at its inactive level.
- R5: `sclk` idles low and each high or low half period lasts `CLK_DIV` system clocks. Consecutive rising edges within a word are therefore `2*CLK_DIV` clocks apart, and `sdo` does not change while `sclk` is high.
- R6: `len_code` sets the word length. Codes 1 to 15 give that many bits (binary 1000 gives 8 bits), and code 0 gives 16 bits. Only the low bits of each data word that fit the length are sent.
- R7: With `lsb_first` at 0 the most significant bit of the word goes first. With `lsb_first` at 1 bit 0 goes first.
- R8: Bit i of an entry's pattern being 1 puts `cs_out[i]` at its active level for the entry's whole transfer. The active level is high when `cs_act_high[i]` is 1 and low when it is 0. Lines not selected, and all lines between entries, sit at the inactive level.
- R9: `cnt_wdata` (4 bits, written by `cnt_wr`) sets the burst length: 1 to 15 entries, with 0 meaning 16. `done_irq` is a one-cycle pulse in the cycle the last counted entry's chip select is released. No further entry is shifted until `ptr_clr`.
- R10: If the queue is empty before the count is reached, `sclk` holds low, no line is selected and no `done_irq` is raised. Shifting continues when a new entry is written.
- R11: Entries are transmitted in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_wr | input | 1 | Stage a chip-select pattern |
| cs_wdata | input | CS_N | Chip-select pattern to stage |
| dat_wr | input | 1 | Write a data word and commit the entry |
| dat_wdata | input | DATA_W | Data word |
| ptr_clr | input | 1 | Empty the queue and restart the burst |
| cnt_wr | input | 1 | Load the burst item count |
| cnt_wdata | input | 4 | Burst item count (0 means 16) |
| tx_en | input | 1 | Transmit enable |
| lsb_first | input | 1 | Bit order, 0 = MSB first |
| len_code | input | LEN_W | Word length code (0 means DATA_W) |
| cs_act_high | input | CS_N | Per-line active level, 1 = active high |
| fifo_full | output | 1 | Queue holds DEPTH entries |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data out |
| cs_out | output | CS_N | Chip-select lines |
| done_irq | output | 1 | Burst-complete pulse |

## Verification
The bench targets four risky cases.

- **Underflow wait mid-burst.** A design that lets the clock run or raises completion early would show stray clock edges or an early pulse.
- **Writes into a full queue.** A design that overwrites on a full write would transmit the extra word in place of a stored one.
- **Data left over from before a pointer clear.** A design that clears only one pointer would replay those stale entries.
- **Writes after a completed burst.** A design that does not stop after the count would keep shifting them.

Randomized bursts vary the word length, including the code that means full width, along with bit order, per-line polarity and per-entry chip-select patterns. A swapped order, an off-by-one length or a misrouted select line then shows up as a wrong reconstructed word.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HALT  = 2'd2
    } eng_state_e;

    // Burst length from the 4-bit count register: zero stands for sixteen.
    function automatic logic [4:0] burst_target(input logic [3:0] code);
        return (code == 4'd0) ? 5'd16 : {1'b0, code};
    endfunction

endpackage

// File: rtl/qspi_entry_queue.sv
module qspi_entry_queue #(
    parameter int DEPTH  = 16,
    parameter int ENT_W  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [ENT_W-1:0] push_ent,
    input  logic             pop,
    output logic [ENT_W-1:0] head_ent,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [OCC_W-1:0] occ;
    } q_state_t;

    q_state_t q_q, q_d;
    logic [ENT_W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (q_q.occ == OCC_W'(DEPTH));
    assign empty    = (q_q.occ == '0);
    assign do_push  = push && !full && !clr;
    assign do_pop   = pop && !empty && !clr;
    assign head_ent = mem_q[q_q.rd_ptr];

    always_comb begin
        q_d = q_q;
        if (clr) begin
            q_d = '0;
        end else begin
            if (do_push) q_d.wr_ptr = bump(q_q.wr_ptr);
            if (do_pop)  q_d.rd_ptr = bump(q_q.rd_ptr);
            case ({do_push, do_pop})
                2'b10:   q_d.occ = q_q.occ + 1'b1;
                2'b01:   q_d.occ = q_q.occ - 1'b1;
                default: q_d.occ = q_q.occ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[q_q.wr_ptr] <= push_ent;
    end

    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> full); // R2
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && !full)); // R3
    AST_POP_ONLY_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R11
endmodule

// File: rtl/qspi_shift_engine.sv
module qspi_shift_engine
    import qspi_pkg::*;
#(
    parameter int CS_N    = 4,
    parameter int DATA_W  = 16,
    parameter int CLK_DIV = 2,
    parameter int LEN_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              lsb_first,
    input  logic [LEN_W-1:0]  len_code,
    input  logic [4:0]        target,
    input  logic              q_empty,
    input  logic [CS_N-1:0]   q_cs,
    input  logic [DATA_W-1:0] q_data,
    output logic              pop,
    output logic              sclk,
    output logic              sdo,
    output logic [CS_N-1:0]   sel,
    output logic              irq
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int CNT_W = LEN_W + 1;

    typedef struct packed {
        eng_state_e        st;
        logic [DATA_W-1:0] shreg;
        logic [CNT_W-1:0]  bitidx;
        logic [CNT_W-1:0]  len;
        logic              lsb;
        logic [DIV_W-1:0]  div;
        logic              sclk;
        logic [CS_N-1:0]   sel;
        logic [4:0]        sent;
        logic              irq;
    } eng_t;

    eng_t e_q, e_d;
    logic [CNT_W-1:0] len_bits;
    logic [LEN_W-1:0] top_idx;

    assign len_bits = (len_code == '0) ? CNT_W'(DATA_W) : {1'b0, len_code};
    assign top_idx  = LEN_W'(e_q.len - 1'b1);
    assign sdo      = e_q.lsb ? e_q.shreg[0] : e_q.shreg[top_idx];
    assign sclk     = e_q.sclk;
    assign sel      = e_q.sel;
    assign irq      = e_q.irq;

    always_comb begin
        e_d     = e_q;
        e_d.irq = 1'b0;
        pop     = 1'b0;
        if (clr) begin
            e_d.st   = ST_WAIT;
            e_d.sent = '0;
            e_d.sclk = 1'b0;
            e_d.sel  = '0;
        end else if (!en) begin
            e_d.st   = (e_q.st == ST_HALT) ? ST_HALT : ST_WAIT;
            e_d.sclk = 1'b0;
            e_d.sel  = '0;
        end else begin
            case (e_q.st)
                ST_WAIT: begin
                    if (!q_empty) begin
                        pop        = 1'b1;
                        e_d.st     = ST_SHIFT;
                        e_d.shreg  = q_data;
                        e_d.sel    = q_cs;
                        e_d.lsb    = lsb_first;
                        e_d.len    = len_bits;
                        e_d.bitidx = '0;
                        e_d.div    = '0;
                        e_d.sclk   = 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (e_q.div == DIV_W'(CLK_DIV - 1)) begin
                        e_d.div = '0;
                        if (!e_q.sclk) begin
                            e_d.sclk = 1'b1;
                        end else begin
                            e_d.sclk = 1'b0;
                            if (e_q.bitidx == e_q.len - 1'b1) begin
                                e_d.sel  = '0;
                                e_d.sent = e_q.sent + 1'b1;
                                if (e_q.sent + 1'b1 == target) begin
                                    e_d.irq = 1'b1;
                                    e_d.st  = ST_HALT;
                                end else begin
                                    e_d.st  = ST_WAIT;
                                end
                            end else begin
                                e_d.bitidx = e_q.bitidx + 1'b1;
                                e_d.shreg  = e_q.lsb ? (e_q.shreg >> 1) : (e_q.shreg << 1);
                            end
                        end
                    end else begin
                        e_d.div = e_q.div + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q     <= '0;
            e_q.st  <= ST_WAIT;
            e_q.len <= CNT_W'(DATA_W);
        end else begin
            e_q <= e_d;
        end
    end

    AST_QUIET_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sclk && sel == '0)); // R4
    AST_SDO_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(sdo)); // R5
    AST_SELECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == ST_SHIFT && $past(e_q.st == ST_SHIFT)) |-> $stable(sel)); // R8
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R9
    AST_HALT_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == ST_HALT && !clr) |=> (e_q.st == ST_HALT && !sclk)); // R9
    AST_WAIT_CLOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == ST_WAIT) |-> (!sclk && sel == '0)); // R10
endmodule

// File: rtl/qspi_tx_fifo.sv
module qspi_tx_fifo
    import qspi_pkg::*;
#(
    parameter int CS_N    = 4,
    parameter int DATA_W  = 16,
    parameter int DEPTH   = 16,
    parameter int CLK_DIV = 2,
    localparam int LEN_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_wr,
    input  logic [CS_N-1:0]   cs_wdata,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] dat_wdata,
    input  logic              ptr_clr,
    input  logic              cnt_wr,
    input  logic [3:0]        cnt_wdata,
    input  logic              tx_en,
    input  logic              lsb_first,
    input  logic [LEN_W-1:0]  len_code,
    input  logic [CS_N-1:0]   cs_act_high,
    output logic              fifo_full,
    output logic              sclk,
    output logic              sdo,
    output logic [CS_N-1:0]   cs_out,
    output logic              done_irq
);
    localparam int ENT_W = CS_N + DATA_W;

    typedef struct packed {
        logic [CS_N-1:0] cs_stage;
        logic [3:0]      count;
    } host_t;

    host_t h_q, h_d;
    logic [ENT_W-1:0] head_ent;
    logic q_empty, q_pop;
    logic [CS_N-1:0] sel;

    always_comb begin
        h_d = h_q;
        if (cs_wr)  h_d.cs_stage = cs_wdata;
        if (cnt_wr) h_d.count    = cnt_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    qspi_entry_queue #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ptr_clr),
        .push     (dat_wr),
        .push_ent ({h_q.cs_stage, dat_wdata}),
        .pop      (q_pop),
        .head_ent (head_ent),
        .empty    (q_empty),
        .full     (fifo_full)
    );

    qspi_shift_engine #(.CS_N(CS_N), .DATA_W(DATA_W), .CLK_DIV(CLK_DIV), .LEN_W(LEN_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ptr_clr),
        .en        (tx_en),
        .lsb_first (lsb_first),
        .len_code  (len_code),
        .target    (burst_target(h_q.count)),
        .q_empty   (q_empty),
        .q_cs      (head_ent[ENT_W-1:DATA_W]),
        .q_data    (head_ent[DATA_W-1:0]),
        .pop       (q_pop),
        .sclk      (sclk),
        .sdo       (sdo),
        .sel       (sel),
        .irq       (done_irq)
    );

    // Each line sits at its active level exactly when selected.
    generate
        for (genvar i = 0; i < CS_N; i++) begin : g_cs
            assign cs_out[i] = ~(sel[i] ^ cs_act_high[i]);
        end
    endgenerate

    AST_IRQ_RELEASES_CS: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> (cs_out == ~cs_act_high)); // R8
    AST_NO_CLOCK_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !$past(tx_en)) |-> !sclk); // R4
endmodule

// File: tb/sim_qspi_tx_fifo.sv
module sim_qspi_tx_fifo;
    localparam int CLK_DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_wr = 1'b0, dat_wr = 1'b0, ptr_clr = 1'b0, cnt_wr = 1'b0;
    logic        tx_en = 1'b0, lsb_first = 1'b0;
    logic [3:0]  cs_wdata = '0, cnt_wdata = '0, len_code = 4'd8, cs_act_high = '0;
    logic [15:0] dat_wdata = '0;
    logic        fifo_full, sclk, sdo, done_irq;
    logic [3:0]  cs_out;

    always #5 clk = ~clk;

    qspi_tx_fifo #(.CLK_DIV(CLK_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_wr(cs_wr), .cs_wdata(cs_wdata),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .ptr_clr(ptr_clr),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .tx_en(tx_en),
        .lsb_first(lsb_first), .len_code(len_code), .cs_act_high(cs_act_high),
        .fifo_full(fifo_full), .sclk(sclk), .sdo(sdo), .cs_out(cs_out),
        .done_irq(done_irq)
    );

    int n_checks = 0, n_fail = 0;
    int exp_n = 0;
    logic [15:0] exp_d [256];
    logic [3:0]  exp_cs [256];

    // Observer state, written only by the sampler below.
    int rx_cnt = 0, irq_cnt = 0, irq_rx = 0, irq_long = 0;
    int stray_clk = 0, timing_err = 0, sdo_err = 0, cyc = 0, last_rise = 0;
    logic [15:0] rx_bits [256];
    int          rx_n [256];
    logic [3:0]  rx_sel [256];
    logic [15:0] cur_bits = '0;
    int          cur_n = 0;
    logic [3:0]  cur_sel = '0, prev_sel = '0;
    logic        prev_sclk = 1'b0, prev_sdo = 1'b0, prev_irq = 1'b0;

    always @(negedge clk) begin
        logic [3:0] sel_now;
        cyc++;
        if (rst_n) begin
            sel_now = ~(cs_out ^ cs_act_high);
            if (sclk && !prev_sclk) begin
                if (sel_now == 4'd0 || !tx_en) stray_clk++;
                if (cur_n > 0 && (cyc - last_rise) != 2 * CLK_DIV) timing_err++;
                if (cur_n < 16) cur_bits[cur_n] = sdo;
                cur_n++;
                last_rise = cyc;
                cur_sel = sel_now;
            end
            if (sclk && prev_sclk && sdo != prev_sdo) sdo_err++;
            if (prev_sel != 4'd0 && sel_now == 4'd0) begin
                rx_bits[rx_cnt % 256] = cur_bits;
                rx_n[rx_cnt % 256]    = cur_n;
                rx_sel[rx_cnt % 256]  = cur_sel;
                rx_cnt++;
                cur_n = 0;
                cur_bits = '0;
            end
            if (done_irq) begin
                irq_cnt++;
                irq_rx = rx_cnt;
                if (prev_irq) irq_long++;
            end
            prev_sel  = sel_now;
            prev_sclk = sclk;
            prev_sdo  = sdo;
            prev_irq  = done_irq;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic int len_of(input logic [3:0] code);
        return (code == 4'd0) ? 16 : int'(code);
    endfunction

    function automatic logic [15:0] assemble(input logic [15:0] bits, input int n, input bit lsb);
        logic [15:0] v = '0;
        for (int i = 0; i < n && i < 16; i++) begin
            if (lsb) v[i] = bits[i];
            else     v = {v[14:0], bits[i]};
        end
        return v;
    endfunction

    function automatic logic [15:0] mask_len(input logic [15:0] d, input int n);
        return (n >= 16) ? d : (d & ((16'd1 << n) - 16'd1));
    endfunction

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr_cs(input logic [3:0] p);
        step(); cs_wr = 1'b1; cs_wdata = p;
        step(); cs_wr = 1'b0;
    endtask

    task automatic wr_dat(input logic [15:0] d);
        step(); dat_wr = 1'b1; dat_wdata = d;
        step(); dat_wr = 1'b0;
    endtask

    task automatic push(input logic [3:0] p, input logic [15:0] d, input bit record);
        wr_cs(p);
        wr_dat(d);
        if (record) begin
            exp_cs[exp_n % 256] = p;
            exp_d[exp_n % 256]  = d;
            exp_n++;
        end
    endtask

    task automatic clear_ptrs();
        step(); ptr_clr = 1'b1;
        step(); ptr_clr = 1'b0;
    endtask

    task automatic set_count(input logic [3:0] c);
        step(); cnt_wr = 1'b1; cnt_wdata = c;
        step(); cnt_wr = 1'b0;
    endtask

    task automatic wait_irq(input int target_cnt);
        for (int i = 0; i < 8000 && irq_cnt < target_cnt; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Compare received words against the recorded entries.
    task automatic check_burst(input int rx_base, input int ex_base, input int n,
                               input string req);
        int lb;
        lb = len_of(len_code);
        chk(rx_cnt - rx_base == n, req, "word count", rx_cnt - rx_base, n);
        for (int k = 0; k < n; k++) begin
            int r, e;
            r = (rx_base + k) % 256;
            e = (ex_base + k) % 256;
            chk(rx_n[r] == lb, "R6", "bits per word", rx_n[r], lb);
            chk(assemble(rx_bits[r], rx_n[r], lsb_first) == mask_len(exp_d[e], lb),
                lsb_first ? "R7" : "R11", "word value",
                assemble(rx_bits[r], rx_n[r], lsb_first), mask_len(exp_d[e], lb));
            chk(rx_sel[r] == exp_cs[e], "R8", "select pattern", rx_sel[r], exp_cs[e]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int rb, eb, ib, dummy;
        dummy = $urandom(32'h5EED_0042);
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk(sclk == 1'b0, "R5", "reset sclk", sclk, 0);
        chk(cs_out == 4'hF, "R8", "reset cs_out", cs_out, 4'hF);
        chk(done_irq == 1'b0, "R9", "reset irq", done_irq, 0);
        chk(fifo_full == 1'b0, "R2", "reset full", fifo_full, 0);

        // Directed example: three slaves, 8-bit MSB first, active low
        clear_ptrs(); set_count(4'd3);
        rb = rx_cnt; eb = exp_n; ib = irq_cnt;
        push(4'b0001, 16'h0055, 1); push(4'b0010, 16'h00AA, 1); push(4'b0100, 16'h00CC, 1);
        step(); tx_en = 1'b1;
        wait_irq(ib + 1);
        check_burst(rb, eb, 3, "R11");
        chk(irq_cnt - ib == 1, "R9", "one completion pulse", irq_cnt - ib, 1);
        chk(irq_rx == rb + 3, "R9", "pulse with last release", irq_rx, rb + 3);
        // R9: nothing more is shifted after completion until a clear
        push(4'b1000, 16'h00F0, 0);
        idle(300);
        chk(rx_cnt == rb + 3, "R9", "no shift after done", rx_cnt, rb + 3);
        step(); tx_en = 1'b0;

        // R10: underflow wait mid-burst
        clear_ptrs(); set_count(4'd3);
        rb = rx_cnt; eb = exp_n; ib = irq_cnt;
        step(); tx_en = 1'b1;
        push(4'b0100, 16'h0012, 1);
        idle(400);
        chk(rx_cnt - rb == 1, "R10", "one word before wait", rx_cnt - rb, 1);
        chk(irq_cnt == ib, "R10", "no pulse while waiting", irq_cnt, ib);
        chk(sclk == 1'b0 && cs_out == 4'hF, "R10", "idle during wait", {sclk, cs_out}, 5'h0F);
        push(4'b0001, 16'h0034, 1); push(4'b1000, 16'h00E7, 1);
        wait_irq(ib + 1);
        check_burst(rb, eb, 3, "R10");
        step(); tx_en = 1'b0;

        // R1: chip-select writes alone queue nothing
        clear_ptrs(); set_count(4'd1);
        rb = rx_cnt; ib = irq_cnt;
        step(); tx_en = 1'b1;
        wr_cs(4'b0001); wr_cs(4'b0010); wr_cs(4'b1000);
        idle(200);
        chk(rx_cnt == rb, "R1", "select write sends nothing", rx_cnt, rb);
        eb = exp_n;
        wr_dat(16'h003C);
        exp_cs[exp_n % 256] = 4'b1000; exp_d[exp_n % 256] = 16'h003C; exp_n++;
        wait_irq(ib + 1);
        check_burst(rb, eb, 1, "R1");
        step(); tx_en = 1'b0;

        // R4: no transmission while disabled
        clear_ptrs(); set_count(4'd2);
        rb = rx_cnt; eb = exp_n; ib = irq_cnt;
        push(4'b0010, 16'h0081, 1); push(4'b0001, 16'h007E, 1);
        idle(400);
        chk(rx_cnt == rb, "R4", "disabled sends nothing", rx_cnt, rb);
        chk(sclk == 1'b0, "R4", "disabled sclk low", sclk, 0);
        step(); tx_en = 1'b1;
        wait_irq(ib + 1);
        check_burst(rb, eb, 2, "R4");
        step(); tx_en = 1'b0;

        // R2: fill to full, extra write dropped, count 0 means 16 (R9)
        clear_ptrs(); set_count(4'd0);
        rb = rx_cnt; eb = exp_n; ib = irq_cnt;
        for (int i = 0; i < 16; i++)
            push(4'(1 << ($urandom % 4)), 16'($urandom), 1);
        @(negedge clk);
        chk(fifo_full == 1'b1, "R2", "full after 16", fifo_full, 1);
        push(4'b1111, 16'h00FF, 0);
        @(negedge clk);
        chk(fifo_full == 1'b1, "R2", "full after dropped write", fifo_full, 1);
        step(); tx_en = 1'b1;
        wait_irq(ib + 1);
        check_burst(rb, eb, 16, "R2");
        chk(irq_rx == rb + 16, "R9", "count zero is sixteen", irq_rx - rb, 16);
        chk(fifo_full == 1'b0, "R2", "not full after drain", fifo_full, 0);
        step(); tx_en = 1'b0;

        // R3: clear discards stored entries
        clear_ptrs(); set_count(4'd1);
        rb = rx_cnt;
        for (int i = 0; i < 16; i++) push(4'b0001, 16'(i), 0);
        clear_ptrs();
        @(negedge clk);
        chk(fifo_full == 1'b0, "R3", "clear drops full", fifo_full, 0);
        step(); tx_en = 1'b1;
        idle(300);
        chk(rx_cnt == rb, "R3", "stale entries not sent", rx_cnt, rb);
        step(); tx_en = 1'b0;

        // Random bursts: length, order, polarity, patterns (R6 R7 R8)
        for (int b = 0; b < 8; b++) begin
            int n;
            n = 1 + int'($urandom % 8);
            clear_ptrs();
            step();
            len_code    = 4'($urandom);
            lsb_first   = 1'($urandom);
            cs_act_high = 4'($urandom);
            set_count(4'(n));
            rb = rx_cnt; eb = exp_n; ib = irq_cnt;
            for (int i = 0; i < n; i++) begin
                logic [3:0] p;
                p = 4'($urandom);
                if (p == 4'd0) p = 4'b0100;
                push(p, 16'($urandom), 1);
            end
            step(); tx_en = 1'b1;
            wait_irq(ib + 1);
            check_burst(rb, eb, n, lsb_first ? "R7" : "R6");
            chk(cs_out == ~cs_act_high, "R8", "inactive after burst", cs_out, ~cs_act_high);
            step(); tx_en = 1'b0;
        end

        idle(10);
        chk(timing_err == 0, "R5", "half-period violations", timing_err, 0);
        chk(sdo_err == 0, "R5", "sdo moved while sclk high", sdo_err, 0);
        chk(stray_clk == 0, "R4", "clock edges without selection", stray_clk, 0);
        chk(irq_long == 0, "R9", "multi-cycle pulses", irq_long, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule